// File: doc/BRIEF.md
# Systolic Least-Squares Pilot Correlator

This block forms a least-squares channel estimate for every receive antenna. It multiplies the received pilot matrix (M antennas by L pilot symbols) by the conjugate of a known training sequence of length L. The work is done in a linear chain of L processing elements. Element l holds training symbol l. It also holds the received column that goes with that symbol. Each element does one complex multiply and one complex add per step. Partial sums move one element down the chain per step, so the last element hands out one finished antenna sum per cycle. A registered output stage rounds that sum, scales it down by 2^SH and saturates it. Results stream out in antenna order.

The received matrix arrives one full column (all M antenna samples) per clock. Each element has a small shift register that captures its own column when the column arrives. The register then releases one sample per step, which gives the diagonal skew a systolic array needs. The same array serves every estimation slot, including the preamble and the uplink training. A start pulse loads a new training sequence, and the following L columns make up the frame.

A three-state controller sequences each frame. IDLE moves to COLLECT on `start`, and the pilot registers load on that same edge. COLLECT stays in COLLECT while `in_valid` is low (a stall). It counts accepted columns and moves to DRAIN when the L-th column is accepted. DRAIN runs for exactly M+1 cycles while the chain empties, then moves back to IDLE.

Top module: `ls_pilot_correlator`

## Requirements
- R1: After reset, `out_valid` is 0, `out_re` and `out_im` are 0, and the controller is in IDLE.
- R2: A `start` pulse in IDLE captures `pilot_re`/`pilot_im`, where symbol l sits in bits [l*PW +: PW]. A `start` seen in COLLECT or DRAIN has no effect on the frame in progress or on the pilots it uses.
- R3: `in_valid` in IDLE is ignored: no result is produced, and the next frame is unaffected.
- R4: The result for antenna m is round_sat((S[m]) / 2^SH). S[m] is the sum over l of Y[m][l]·conj(x[l]). Sample Y[m][l] of a column sits in bits [m*DW +: DW] of `col_re`/`col_im`. All values are two's-complement signed.
- R5: The training symbol is conjugated. The real part is Σ(yr·xr + yi·xi) and the imaginary part is Σ(yi·xr − yr·xi).
- R6: The L-th column is accepted on edge E. `out_valid` stays low one cycle, then is high for exactly M consecutive cycles starting after edge E+2, and carries antennas 0..M−1 in order. It is low at all other times.
- R7: A cycle with `in_valid` low during COLLECT freezes the array. The results do not change, and the latency counted from the last accepted column does not change.
- R8: Rounding is half-up: (S + 2^(SH−1)) is arithmetically shifted right by SH.
- R9: A rounded value outside [−2^(OW−1), 2^(OW−1)−1] is clipped to the nearest limit.
- R10: Frames run back to back, each with its own pilots, and no result depends on an earlier frame.
- R11: While `out_valid` is low, `out_re` and `out_im` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start; loads pilots when idle |
| pilot_re | input | L*PW | Training symbols, real parts |
| pilot_im | input | L*PW | Training symbols, imaginary parts |
| in_valid | input | 1 | Received column present |
| col_re | input | M*DW | Received column, real parts |
| col_im | input | M*DW | Received column, imaginary parts |
| out_valid | output | 1 | Estimate present |
| out_re | output | OW | Estimate, real part |
| out_im | output | OW | Estimate, imaginary part |

## Verification
The frames use several pilot patterns, and each one isolates a different part of the arithmetic. A lone unit real pilot with data at the half-step points isolates the rounding direction for both signs. Purely imaginary pilots show whether the conjugate is applied and whether the cross terms carry the right signs. Full-scale data against full-scale pilots drives both limits of the clipping. A long run of pseudo-random frames then covers the general sum and any state left over from earlier frames. Stalls in the column stream, a start pulse with different pilots in the middle of a frame, and columns offered while idle show that the skew alignment and the frame boundaries are held. Exact latency and burst length are checked on every frame.

// File: rtl/ls_corr_pkg.sv
package ls_corr_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_DRAIN   = 2'd2
    } corr_state_e;

endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
    import ls_corr_pkg::*;
#(
    parameter int M   = 4,
    parameter int L   = 4,
    parameter int CW  = 2,
    parameter int DCW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    output corr_state_e       state,
    output logic [CW-1:0]     col_cnt,
    output logic              load_pilot,
    output logic              emit
);

    corr_state_e      state_nx;
    logic [DCW-1:0]   drain_cnt;
    logic             last_col;
    logic             drain_done;

    assign last_col   = (col_cnt == CW'(L - 1));
    assign drain_done = (drain_cnt == DCW'(M));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start)                state_nx = S_COLLECT;
            S_COLLECT: if (in_valid && last_col) state_nx = S_DRAIN;
            S_DRAIN:   if (drain_done)           state_nx = S_IDLE;
            default:                             state_nx = S_IDLE;
        endcase
    end

    // frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_cnt   <= '0;
            drain_cnt <= '0;
        end else begin
            if (state == S_COLLECT) begin
                if (in_valid) col_cnt <= last_col ? '0 : col_cnt + 1'b1;
            end else begin
                col_cnt <= '0;
            end
            if (state == S_DRAIN) drain_cnt <= drain_done ? '0 : drain_cnt + 1'b1;
            else                  drain_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        load_pilot = 1'b0;
        emit       = 1'b0;
        unique case (state)
            S_IDLE:    load_pilot = start;
            S_COLLECT: ;
            S_DRAIN:   emit = (drain_cnt != '0);
            default:   ;
        endcase
    end

endmodule

// File: rtl/lsc_pe.sv
module lsc_pe #(
    parameter int M  = 4,
    parameter int DW = 6,
    parameter int PW = 4,
    parameter int AW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_pilot,
    input  logic [PW-1:0]        pilot_re,
    input  logic [PW-1:0]        pilot_im,
    input  logic                 capture,
    input  logic                 advance,
    input  logic [M*DW-1:0]      col_re,
    input  logic [M*DW-1:0]      col_im,
    input  logic signed [AW-1:0] ps_in_re,
    input  logic signed [AW-1:0] ps_in_im,
    output logic signed [AW-1:0] ps_out_re,
    output logic signed [AW-1:0] ps_out_im
);

    logic signed [PW-1:0] tr_re, tr_im;
    logic signed [DW-1:0] sk_re [M];
    logic signed [DW-1:0] sk_im [M];

    logic signed [AW-1:0] h_re, h_im, x_re, x_im;
    logic signed [AW-1:0] term_re, term_im;

    // training symbol register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_re <= '0;
            tr_im <= '0;
        end else if (load_pilot) begin
            tr_re <= pilot_re;
            tr_im <= pilot_im;
        end
    end

    // skew register: parallel capture of own column, serial release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < M; i++) begin
                sk_re[i] <= '0;
                sk_im[i] <= '0;
            end
        end else if (capture) begin
            for (int i = 0; i < M; i++) begin
                sk_re[i] <= col_re[i*DW +: DW];
                sk_im[i] <= col_im[i*DW +: DW];
            end
        end else if (advance) begin
            for (int i = 0; i < M - 1; i++) begin
                sk_re[i] <= sk_re[i+1];
                sk_im[i] <= sk_im[i+1];
            end
            sk_re[M-1] <= '0;
            sk_im[M-1] <= '0;
        end
    end

    assign h_re = AW'(sk_re[0]);
    assign h_im = AW'(sk_im[0]);
    assign x_re = AW'(tr_re);
    assign x_im = AW'(tr_im);

    // y * conj(x)
    assign term_re = h_re * x_re + h_im * x_im;
    assign term_im = h_im * x_re - h_re * x_im;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_out_re <= '0;
            ps_out_im <= '0;
        end else if (advance) begin
            ps_out_re <= ps_in_re + term_re;
            ps_out_im <= ps_in_im + term_im;
        end
    end

endmodule

// File: rtl/lsc_outstage.sv
module lsc_outstage #(
    parameter int AW = 14,
    parameter int OW = 8,
    parameter int SH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 emit,
    input  logic signed [AW-1:0] acc_re,
    input  logic signed [AW-1:0] acc_im,
    output logic                 out_valid,
    output logic [OW-1:0]        out_re,
    output logic [OW-1:0]        out_im
);

    localparam int XW = AW + 1;
    localparam logic signed [XW-1:0] HALF = (SH > 0) ? XW'(1) <<< (SH - 1) : '0;
    localparam logic signed [XW-1:0] OMAX = XW'((64'sd1 <<< (OW - 1)) - 1);
    localparam logic signed [XW-1:0] OMIN = -OMAX - XW'(1);

    function automatic logic [OW-1:0] round_sat(input logic signed [AW-1:0] a);
        logic signed [XW-1:0] t;
        t = (XW'(a) + HALF) >>> SH;
        if (t > OMAX)      return OMAX[OW-1:0];
        else if (t < OMIN) return OMIN[OW-1:0];
        else               return t[OW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= emit;
            out_re    <= emit ? round_sat(acc_re) : '0;
            out_im    <= emit ? round_sat(acc_im) : '0;
        end
    end

endmodule

// File: rtl/ls_pilot_correlator.sv
module ls_pilot_correlator
    import ls_corr_pkg::*;
#(
    parameter int M  = 4,
    parameter int L  = 4,
    parameter int DW = 6,
    parameter int PW = 4,
    parameter int OW = 8,
    parameter int SH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [L*PW-1:0]   pilot_re,
    input  logic [L*PW-1:0]   pilot_im,
    input  logic              in_valid,
    input  logic [M*DW-1:0]   col_re,
    input  logic [M*DW-1:0]   col_im,
    output logic              out_valid,
    output logic [OW-1:0]     out_re,
    output logic [OW-1:0]     out_im
);

    localparam int CW  = (L > 1) ? $clog2(L) : 1;
    localparam int DCW = $clog2(M + 1);
    localparam int AW  = DW + PW + 2 + ((L > 1) ? $clog2(L) : 0);

    corr_state_e      state;
    logic [CW-1:0]    col_cnt;
    logic             load_pilot;
    logic             emit;
    logic             advance;
    logic             accept;

    logic signed [AW-1:0] ps_re [L+1];
    logic signed [AW-1:0] ps_im [L+1];

    lsc_ctrl #(.M(M), .L(L), .CW(CW), .DCW(DCW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .state      (state),
        .col_cnt    (col_cnt),
        .load_pilot (load_pilot),
        .emit       (emit)
    );

    assign accept  = (state == S_COLLECT) && in_valid;
    assign advance = accept || (state == S_DRAIN);

    assign ps_re[0] = '0;
    assign ps_im[0] = '0;

    for (genvar g = 0; g < L; g++) begin : g_pe
        logic cap;
        assign cap = accept && (col_cnt == CW'(g));

        lsc_pe #(.M(M), .DW(DW), .PW(PW), .AW(AW)) u_pe (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_pilot (load_pilot),
            .pilot_re   (pilot_re[g*PW +: PW]),
            .pilot_im   (pilot_im[g*PW +: PW]),
            .capture    (cap),
            .advance    (advance),
            .col_re     (col_re),
            .col_im     (col_im),
            .ps_in_re   (ps_re[g]),
            .ps_in_im   (ps_im[g]),
            .ps_out_re  (ps_re[g+1]),
            .ps_out_im  (ps_im[g+1])
        );
    end

    lsc_outstage #(.AW(AW), .OW(OW), .SH(SH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .acc_re    (ps_re[L]),
        .acc_im    (ps_im[L]),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

endmodule

// File: rtl/ls_pilot_correlator_chk.sv
module ls_pilot_correlator_chk
    import ls_corr_pkg::*;
#(
    parameter int M  = 4,
    parameter int L  = 4,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          in_valid,
    input logic          out_valid,
    input corr_state_e   state,
    input logic [CW-1:0] col_cnt
);

    localparam int VW = $clog2(M + 1) + 1;
    logic [VW-1:0] vrun;

    always_ff @(posedge clk) begin
        if (!rst_n)                      vrun <= '0;
        else if (!out_valid)             vrun <= '0;
        else if (vrun != {VW{1'b1}})     vrun <= vrun + 1'b1;
    end

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> (state == S_IDLE));

    p_start_in_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (state == S_COLLECT));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && !in_valid) |=> (state == S_COLLECT && $stable(col_cnt)));

    p_collect_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && in_valid && col_cnt == CW'(L - 1)) |=> (state == S_DRAIN));

    p_valid_from_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == S_DRAIN));

    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (vrun < VW'(M)));

endmodule

bind ls_pilot_correlator ls_pilot_correlator_chk #(.M(M), .L(L), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .state     (state),
    .col_cnt   (col_cnt)
);

// File: tb/ls_pilot_correlator_tb_top.sv
module ls_pilot_correlator_tb_top;

    localparam int M  = 4;
    localparam int L  = 4;
    localparam int DW = 6;
    localparam int PW = 4;
    localparam int OW = 8;
    localparam int SH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [L*PW-1:0]   pilot_re = '0;
    logic [L*PW-1:0]   pilot_im = '0;
    logic              in_valid = 1'b0;
    logic [M*DW-1:0]   col_re = '0;
    logic [M*DW-1:0]   col_im = '0;
    logic              out_valid;
    logic [OW-1:0]     out_re;
    logic [OW-1:0]     out_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int yre [M][L];
    int yim [M][L];
    int xre [L];
    int xim [L];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    ls_pilot_correlator #(.M(M), .L(L), .DW(DW), .PW(PW), .OW(OW), .SH(SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pilot_re(pilot_re), .pilot_im(pilot_im),
        .in_valid(in_valid), .col_re(col_re), .col_im(col_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 32'd1103515245 + 32'd12345;
        return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
    endfunction

    function automatic int round_sat(input int a);
        int t;
        int hi;
        t  = (a + (1 << (SH - 1))) >>> SH;
        hi = (1 << (OW - 1)) - 1;
        if (t > hi)      return hi;
        if (t < -hi - 1) return -hi - 1;
        return t;
    endfunction

    task automatic put_col(input int l);
        for (int m = 0; m < M; m++) begin
            col_re[m*DW +: DW] = DW'(yre[m][l]);
            col_im[m*DW +: DW] = DW'(yim[m][l]);
        end
    endtask

    // gap_mask bit l: one idle cycle before column l; junk_start: pulse start with other pilots in a gap
    task automatic run_frame(input int gap_mask, input bit junk_start, input string req);
        int er, ei;
        @(negedge clk);
        start = 1'b1;
        for (int l = 0; l < L; l++) begin
            pilot_re[l*PW +: PW] = PW'(xre[l]);
            pilot_im[l*PW +: PW] = PW'(xim[l]);
        end
        @(negedge clk);
        start = 1'b0;
        pilot_re = ~pilot_re;
        pilot_im = pilot_im ^ {L*PW{1'b1}};
        for (int l = 0; l < L; l++) begin
            if (gap_mask[l]) begin
                in_valid = 1'b0;
                start = junk_start;
                @(negedge clk);
                start = 1'b0;
            end
            in_valid = 1'b1;
            put_col(l);
            @(negedge clk);
        end
        in_valid = 1'b0;
        col_re = ~col_re;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "valid one cycle after last column", int'(out_valid), 0);
        for (int m = 0; m < M; m++) begin
            @(negedge clk);
            er = 0;
            ei = 0;
            for (int l = 0; l < L; l++) begin
                er += yre[m][l] * xre[l] + yim[m][l] * xim[l];
                ei += yim[m][l] * xre[l] - yre[m][l] * xim[l];
            end
            er = round_sat(er);
            ei = round_sat(ei);
            chk(out_valid == 1'b1, "R6", "valid in burst", int'(out_valid), 1);
            chk(int'($signed(out_re)) == er, req, "real estimate (R4)", int'($signed(out_re)), er);
            chk(int'($signed(out_im)) == ei, req, "imag estimate (R5)", int'($signed(out_im)), ei);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "valid after burst", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R11", "data zero while not valid", int'(out_re), 0);
    endtask

    task automatic rand_fill();
        for (int l = 0; l < L; l++) begin
            xre[l] = rnd(-8, 7);
            xim[l] = rnd(-8, 7);
            for (int m = 0; m < M; m++) begin
                yre[m][l] = rnd(-32, 31);
                yim[m][l] = rnd(-32, 31);
            end
        end
    endtask

    initial begin
        #2000000;
        $display("FAIL watchdog expired");
        errors++;
        checks++;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R1", "reset data", int'(out_re), 0);

        // R3: columns offered while idle
        in_valid = 1'b1;
        col_re = '1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < L + M + 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R3", "no output from idle input", int'(out_valid), 0);
        end

        // R8: unit pilot, half-step data
        for (int l = 0; l < L; l++) begin
            xre[l] = (l == 0) ? 1 : 0;
            xim[l] = 0;
            for (int m = 0; m < M; m++) begin
                yre[m][l] = rnd(-32, 31);
                yim[m][l] = rnd(-32, 31);
            end
        end
        yre[0][0] = 2;  yim[0][0] = -2;
        yre[1][0] = 3;  yim[1][0] = -3;
        yre[2][0] = 6;  yim[2][0] = -6;
        yre[3][0] = 1;  yim[3][0] = -1;
        run_frame(0, 1'b0, "R8");

        // R5: purely imaginary pilots
        for (int l = 0; l < L; l++) begin
            xre[l] = 0;
            xim[l] = (l % 2 == 0) ? 3 - l : -2 - l;
            for (int m = 0; m < M; m++) begin
                yre[m][l] = rnd(-32, 31);
                yim[m][l] = rnd(-32, 31);
            end
        end
        run_frame(0, 1'b0, "R5");

        // R9: both clip limits
        for (int l = 0; l < L; l++) begin
            xre[l] = 7;
            xim[l] = -8;
            for (int m = 0; m < M; m++) begin
                yre[m][l] = (m % 2 == 0) ? 31 : -32;
                yim[m][l] = (m < 2) ? 0 : ((m % 2 == 0) ? -32 : 31);
            end
        end
        run_frame(0, 1'b0, "R9");

        // R7 and R2: stalls with a start pulse carrying other pilots mid-frame
        rand_fill();
        run_frame(32'b1010, 1'b1, "R7");
        rand_fill();
        run_frame(32'b0111, 1'b1, "R2");
        rand_fill();
        run_frame(32'b0001, 1'b0, "R7");

        // R10 and R4: back-to-back random frames
        for (int f = 0; f < 24; f++) begin
            rand_fill();
            run_frame(0, 1'b0, "R10");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule